// File: doc/BRIEF.md
# Monitor-Arm Instruction Fault Checker

This block screens one decoded user-level monitor-arm instruction before the execution stage acts on it. Each input beat presents the three opcode bytes, the ModRM byte, the lock and address-size prefix flags, an optional segment override, the feature-enable bit, the processor mode, the raw effective address, the selected segment's limit and a null-selector flag. One cycle later the block reports whether the beat really was this instruction and, if so, either an accept with the address cut to the effective address width, or the single highest-priority fault.

The checker does not add segment bases and does not walk page tables; the downstream unit forms the linear address and handles paging faults. Instructions that do not match the encoding pass through with no fault and no accept, so the normal decoder can deal with them.

Top module: `mon_arm_checker`

## Requirements
- R1: A beat is this instruction (out_hit=1) only when op_byte0..2 are F3h, 0Fh, AEh, ModRM bits [7:6] are 11b and ModRM bits [5:3] are 110b; a non-matching beat gives out_hit=0, out_accept=0, out_fault=0 and out_addr=0.
- R2: out_valid rises exactly one cycle after each in_valid cycle and is low one cycle after in_valid is low; payload belongs to that beat.
- R3: A set lock prefix or a cleared feature-enable bit yields fault code 1 (invalid opcode), ahead of every other fault.
- R4: Address width, with mode codes 0 real, 1 virtual-8086, 2 protected, 3 64-bit: mode 3 uses 64 bits, or 32 with the address-size prefix; mode 2 uses 32, or 16 with the prefix; modes 0 and 1 use 16, or 32 with the prefix.
- R5: For a matching beat, out_addr is the effective address zero-extended from the selected width, whatever the fault; out_src carries ModRM bits [2:0].
- R6: The segment is DS (code 3) unless the override flag is set, then the override code (ES 0, CS 1, SS 2, DS 3, FS 4, GS 5); segment SS turns a range violation into fault code 3 (stack), any other segment into code 2 (general protection).
- R7: In protected mode a null selector gives fault code 2, even when the segment is SS and the address also exceeds the limit.
- R8: In protected mode an address above the segment limit is a range violation; an address equal to the limit is not.
- R9: In real and virtual-8086 mode an address above FFFFh is a range violation; the null flag is ignored.
- R10: In 64-bit mode an address whose bits 63 through 47 are not all equal is a range violation.
- R11: out_accept is high exactly when out_valid, out_hit and fault code 0 hold together.
- R12: While reset is asserted and until the first beat, out_valid, out_hit, out_accept, out_fault and out_addr are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Beat present |
| op_byte0 | input | 8 | First opcode byte |
| op_byte1 | input | 8 | Second opcode byte |
| op_byte2 | input | 8 | Third opcode byte |
| modrm | input | 8 | ModRM byte |
| pfx_lock | input | 1 | Lock prefix present |
| pfx_asize | input | 1 | Address-size prefix present |
| seg_ovr_en | input | 1 | Segment override present |
| seg_ovr | input | 3 | Override segment code |
| feat_en | input | 1 | Feature enabled |
| cpu_mode | input | 2 | Processor mode code |
| eff_addr | input | 64 | Raw source register value |
| seg_limit | input | 32 | Limit of the selected segment |
| seg_null | input | 1 | Selected segment holds a null selector |
| out_valid | output | 1 | Result present |
| out_hit | output | 1 | Beat matched the instruction |
| out_accept | output | 1 | Matched and fault-free |
| out_fault | output | 2 | 0 none, 1 invalid opcode, 2 general protection, 3 stack |
| out_addr | output | 64 | Width-truncated address |
| out_src | output | 3 | Source register number |

## Verification
The bench pushes addresses onto each edge: exactly at and one past the protected limit, FFFFh against 10000h in the 16-bit modes, and both sides of the canonical boundary, where an off-by-one compare would flip accept into a fault or hide a real one. It stacks faults on one beat (lock over a non-canonical address, null selector over an SS limit violation) so a wrong priority order would report the lower fault. It feeds near-miss encodings with a wrong mod or reg field, which a loose decoder would accept, and mixes the address-size prefix with every mode so that a swapped width table shows up as upper address bits surviving or vanishing.

// File: rtl/mon_chk_pkg.sv
package mon_chk_pkg;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_UD   = 2'd1,
    FLT_GP   = 2'd2,
    FLT_SS   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } mode_e;

  typedef enum logic [1:0] {
    AW16 = 2'd0,
    AW32 = 2'd1,
    AW64 = 2'd2
  } awidth_e;

  localparam logic [2:0] SEG_SS = 3'd2;
  localparam logic [2:0] SEG_DS = 3'd3;

  localparam logic [7:0] OPC_B0 = 8'hF3;
  localparam logic [7:0] OPC_B1 = 8'h0F;
  localparam logic [7:0] OPC_B2 = 8'hAE;
  localparam logic [2:0] OPC_REG = 3'd6;

endpackage

// File: rtl/mon_decode.sv
module mon_decode
  import mon_chk_pkg::*;
(
  input  logic [7:0] op_byte0,
  input  logic [7:0] op_byte1,
  input  logic [7:0] op_byte2,
  input  logic [7:0] modrm,
  input  logic       pfx_asize,
  input  logic       seg_ovr_en,
  input  logic [2:0] seg_ovr,
  input  mode_e      mode,
  output logic       hit,
  output logic [2:0] src_reg,
  output awidth_e    aw,
  output logic [2:0] seg
);

  logic bytes_ok;
  logic form_ok;

  always_comb begin
    bytes_ok = (op_byte0 == OPC_B0) && (op_byte1 == OPC_B1) && (op_byte2 == OPC_B2);
    form_ok  = (modrm[7:6] == 2'b11) && (modrm[5:3] == OPC_REG);
    hit      = bytes_ok && form_ok;
    src_reg  = modrm[2:0];
    seg      = seg_ovr_en ? seg_ovr : SEG_DS;
  end

  always_comb begin
    unique case (mode)
      MODE_LONG: aw = pfx_asize ? AW32 : AW64;
      MODE_PROT: aw = pfx_asize ? AW16 : AW32;
      default:   aw = pfx_asize ? AW32 : AW16;
    endcase
  end

endmodule

// File: rtl/mon_addr_trunc.sv
module mon_addr_trunc
  import mon_chk_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] ea,
  input  awidth_e           aw,
  output logic [ADDR_W-1:0] taddr
);

  localparam int W16 = (ADDR_W < 16) ? ADDR_W : 16;
  localparam int W32 = (ADDR_W < 32) ? ADDR_W : 32;

  always_comb begin
    taddr = '0;
    unique case (aw)
      AW16:    taddr[W16-1:0] = ea[W16-1:0];
      AW32:    taddr[W32-1:0] = ea[W32-1:0];
      default: taddr          = ea;
    endcase
  end

endmodule

// File: rtl/mon_fault_eval.sv
module mon_fault_eval
  import mon_chk_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int LIMIT_W   = 32,
  parameter int CANON_MSB = 47
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [LIMIT_W-1:0] limit,
  input  logic [2:0]         seg,
  input  mode_e              mode,
  input  logic               lock,
  input  logic               feat_en,
  input  logic               seg_null,
  output fault_e             fault
);

  localparam int HI_W  = ADDR_W - CANON_MSB;
  localparam int PAD_W = ADDR_W - LIMIT_W;

  logic [ADDR_W-1:0] limit_ext;
  logic [HI_W-1:0]   hi_bits;
  logic              over_limit;
  logic              over_16;
  logic              canon_ok;
  fault_e            range_flt;

  always_comb begin
    limit_ext  = {{PAD_W{1'b0}}, limit};
    hi_bits    = addr[ADDR_W-1:CANON_MSB];
    over_limit = addr > limit_ext;
    over_16    = |addr[ADDR_W-1:16];
    canon_ok   = (&hi_bits) || !(|hi_bits);
    range_flt  = (seg == SEG_SS) ? FLT_SS : FLT_GP;
  end

  always_comb begin
    fault = FLT_NONE;
    if (lock || !feat_en) begin
      fault = FLT_UD;
    end else begin
      unique case (mode)
        MODE_PROT: begin
          if (seg_null)        fault = FLT_GP;
          else if (over_limit) fault = range_flt;
        end
        MODE_LONG: if (!canon_ok) fault = range_flt;
        default:   if (over_16)   fault = range_flt;
      endcase
    end
  end

endmodule

// File: rtl/mon_arm_checker.sv
module mon_arm_checker
  import mon_chk_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int LIMIT_W   = 32,
  parameter int CANON_MSB = 47
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        op_byte0,
  input  logic [7:0]        op_byte1,
  input  logic [7:0]        op_byte2,
  input  logic [7:0]        modrm,
  input  logic              pfx_lock,
  input  logic              pfx_asize,
  input  logic              seg_ovr_en,
  input  logic [2:0]        seg_ovr,
  input  logic              feat_en,
  input  logic [1:0]        cpu_mode,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic [LIMIT_W-1:0] seg_limit,
  input  logic              seg_null,
  output logic              out_valid,
  output logic              out_hit,
  output logic              out_accept,
  output logic [1:0]        out_fault,
  output logic [ADDR_W-1:0] out_addr,
  output logic [2:0]        out_src
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  mode_e             mode;
  logic              hit;
  logic [2:0]        src_reg;
  awidth_e           aw;
  logic [2:0]        seg;
  logic [ADDR_W-1:0] taddr;
  fault_e            fault_c;

  assign mode = mode_e'(cpu_mode);

  mon_decode u_dec (
    .op_byte0  (op_byte0),
    .op_byte1  (op_byte1),
    .op_byte2  (op_byte2),
    .modrm     (modrm),
    .pfx_asize (pfx_asize),
    .seg_ovr_en(seg_ovr_en),
    .seg_ovr   (seg_ovr),
    .mode      (mode),
    .hit       (hit),
    .src_reg   (src_reg),
    .aw        (aw),
    .seg       (seg)
  );

  mon_addr_trunc #(.ADDR_W(ADDR_W)) u_trunc (
    .ea   (eff_addr),
    .aw   (aw),
    .taddr(taddr)
  );

  mon_fault_eval #(
    .ADDR_W   (ADDR_W),
    .LIMIT_W  (LIMIT_W),
    .CANON_MSB(CANON_MSB)
  ) u_flt (
    .addr    (taddr),
    .limit   (seg_limit),
    .seg     (seg),
    .mode    (mode),
    .lock    (pfx_lock),
    .feat_en (feat_en),
    .seg_null(seg_null),
    .fault   (fault_c)
  );

  // next state
  logic              valid_d, hit_d, accept_d;
  fault_e            fault_d;
  logic [ADDR_W-1:0] addr_d;
  logic [2:0]        src_d;

  always_comb begin
    valid_d  = in_valid;
    hit_d    = hit;
    accept_d = hit && (fault_c == FLT_NONE);
    fault_d  = hit ? fault_c : FLT_NONE;
    addr_d   = hit ? taddr : '0;
    src_d    = hit ? src_reg : 3'd0;
  end

  // registers
  logic              valid_q, hit_q, accept_q;
  fault_e            fault_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        src_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q  <= 1'b0;
      hit_q    <= 1'b0;
      accept_q <= 1'b0;
      fault_q  <= FLT_NONE;
      addr_q   <= '0;
      src_q    <= 3'd0;
    end else begin
      valid_q <= valid_d;
      if (in_valid) begin
        hit_q    <= hit_d;
        accept_q <= accept_d;
        fault_q  <= fault_d;
        addr_q   <= addr_d;
        src_q    <= src_d;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_hit    = hit_q;
  assign out_accept = accept_q && valid_q;
  assign out_fault  = fault_q;
  assign out_addr   = addr_q;
  assign out_src    = src_q;

  // R2
  beat_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid);

  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> !out_valid);

  // R3
  ud_first_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op_byte0 == OPC_B0 && op_byte1 == OPC_B1 && op_byte2 == OPC_B2 &&
     modrm[7:3] == {2'b11, OPC_REG} && (pfx_lock || !feat_en)) |=> out_fault == FLT_UD);

  // R1
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && op_byte1 != OPC_B1) |=> (!out_hit && !out_accept && out_fault == FLT_NONE));

  // R11
  accept_clean_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_accept |-> (out_valid && out_hit && out_fault == FLT_NONE));

  // R4
  narrow_addr_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && cpu_mode != 2'd3 && pfx_asize == (cpu_mode == 2'd2)) |=> out_addr[ADDR_W-1:16] == '0);

endmodule

// File: tb/tb_mon_arm_checker.sv
module tb_mon_arm_checker;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  op_byte0, op_byte1, op_byte2, modrm;
  logic        pfx_lock, pfx_asize, seg_ovr_en, feat_en, seg_null;
  logic [2:0]  seg_ovr;
  logic [1:0]  cpu_mode;
  logic [63:0] eff_addr;
  logic [31:0] seg_limit;
  logic        out_valid, out_hit, out_accept;
  logic [1:0]  out_fault;
  logic [63:0] out_addr;
  logic [2:0]  out_src;

  always #2 clk = ~clk;

  mon_arm_checker dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_byte0(op_byte0), .op_byte1(op_byte1), .op_byte2(op_byte2), .modrm(modrm),
    .pfx_lock(pfx_lock), .pfx_asize(pfx_asize), .seg_ovr_en(seg_ovr_en), .seg_ovr(seg_ovr),
    .feat_en(feat_en), .cpu_mode(cpu_mode), .eff_addr(eff_addr), .seg_limit(seg_limit),
    .seg_null(seg_null), .out_valid(out_valid), .out_hit(out_hit), .out_accept(out_accept),
    .out_fault(out_fault), .out_addr(out_addr), .out_src(out_src)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        lock;
    logic        feat;
    logic        asz;
    logic        ovr_en;
    logic [2:0]  ovr;
    logic        nul;
    logic [7:0]  rm;
    logic [63:0] ea;
    logic [31:0] lim;
    logic        e_hit;
    logic [1:0]  e_flt;
    logic [63:0] e_addr;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    // R10 canonical top of lower half
    '{2'd3,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,8'hF0,64'h0000_7FFF_FFFF_FFFF,32'h0,1'b1,2'd0,64'h0000_7FFF_FFFF_FFFF},
    // R10 R6 non-canonical, DS -> GP
    '{2'd3,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,8'hF1,64'h0000_8000_0000_0000,32'h0,1'b1,2'd2,64'h0000_8000_0000_0000},
    // R6 non-canonical, SS override -> SS
    '{2'd3,1'b0,1'b1,1'b0,1'b1,3'd2,1'b0,8'hF2,64'h0000_8000_0000_0000,32'h0,1'b1,2'd3,64'h0000_8000_0000_0000},
    // R10 canonical upper half
    '{2'd3,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,8'hF3,64'hFFFF_8000_0000_0000,32'h0,1'b1,2'd0,64'hFFFF_8000_0000_0000},
    // R4 R5 64-bit mode with prefix -> 32-bit
    '{2'd3,1'b0,1'b1,1'b1,1'b0,3'd0,1'b0,8'hF4,64'h1234_5678_9ABC_DEF0,32'h0,1'b1,2'd0,64'h0000_0000_9ABC_DEF0},
    // R3 lock beats non-canonical
    '{2'd3,1'b1,1'b1,1'b0,1'b1,3'd2,1'b0,8'hF0,64'h0000_8000_0000_0000,32'h0,1'b1,2'd1,64'h0000_8000_0000_0000},
    // R3 feature disabled
    '{2'd2,1'b0,1'b0,1'b0,1'b0,3'd0,1'b1,8'hF0,64'h10,32'hFFFF,1'b1,2'd1,64'h10},
    // R8 over limit, DS -> GP
    '{2'd2,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,8'hF5,64'h0001_0000,32'h0000_FFFF,1'b1,2'd2,64'h0001_0000},
    // R8 R6 over limit, SS -> SS
    '{2'd2,1'b0,1'b1,1'b0,1'b1,3'd2,1'b0,8'hF6,64'h0001_0000,32'h0000_FFFF,1'b1,2'd3,64'h0001_0000},
    // R8 equal to limit passes
    '{2'd2,1'b0,1'b1,1'b0,1'b1,3'd5,1'b0,8'hF7,64'h0000_FFFF,32'h0000_FFFF,1'b1,2'd0,64'h0000_FFFF},
    // R7 null beats SS limit fault
    '{2'd2,1'b0,1'b1,1'b0,1'b1,3'd2,1'b1,8'hF0,64'h0002_0000,32'h0000_FFFF,1'b1,2'd2,64'h0002_0000},
    // R4 protected with prefix -> 16-bit
    '{2'd2,1'b0,1'b1,1'b1,1'b0,3'd0,1'b0,8'hF0,64'hFFFF_FFFF_0001_2345,32'h0000_FFFF,1'b1,2'd0,64'h2345},
    // R9 real, 32-bit, above FFFFh, DS -> GP
    '{2'd0,1'b0,1'b1,1'b1,1'b0,3'd0,1'b0,8'hF0,64'h0001_0000,32'h0,1'b1,2'd2,64'h0001_0000},
    // R9 R6 real, SS -> SS
    '{2'd0,1'b0,1'b1,1'b1,1'b1,3'd2,1'b0,8'hF0,64'h0001_0000,32'h0,1'b1,2'd3,64'h0001_0000},
    // R4 real, 16-bit truncation
    '{2'd0,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,8'hF0,64'hABCD_1234_5678,32'h0,1'b1,2'd0,64'h5678},
    // R9 v86, 32-bit, exactly FFFFh
    '{2'd1,1'b0,1'b1,1'b1,1'b0,3'd0,1'b0,8'hF0,64'h0000_FFFF,32'h0,1'b1,2'd0,64'hFFFF},
    // R1 mod=10b is not the instruction
    '{2'd3,1'b1,1'b1,1'b0,1'b0,3'd0,1'b0,8'hB0,64'h0000_8000_0000_0000,32'h0,1'b0,2'd0,64'h0},
    // R1 reg=5 is not the instruction
    '{2'd3,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,8'hE8,64'h1000,32'h0,1'b0,2'd0,64'h0},
    // R9 null flag ignored in real mode
    '{2'd0,1'b0,1'b1,1'b0,1'b0,3'd0,1'b1,8'hF0,64'h10,32'h0,1'b1,2'd0,64'h10}
  };

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    in_valid   = 1'b0;
    op_byte0   = 8'hF3; op_byte1 = 8'h0F; op_byte2 = 8'hAE; modrm = 8'hF0;
    pfx_lock   = 1'b0; pfx_asize = 1'b0; seg_ovr_en = 1'b0; seg_ovr = 3'd0;
    feat_en    = 1'b1; seg_null = 1'b0; cpu_mode = 2'd3;
    eff_addr   = '0; seg_limit = '0;
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    in_valid = 1'b1; pfx_lock = v.lock; feat_en = v.feat; pfx_asize = v.asz;
    seg_ovr_en = v.ovr_en; seg_ovr = v.ovr; seg_null = v.nul; modrm = v.rm;
    cpu_mode = v.mode; eff_addr = v.ea; seg_limit = v.lim;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 valid", {63'd0, out_valid}, 64'd0);
    check("R12 fault", {62'd0, out_fault}, 64'd0);
    check("R12 addr", out_addr, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 valid after release", {63'd0, out_valid}, 64'd0);
    check("R12 accept after release", {63'd0, out_accept}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      check("R2 valid", {63'd0, out_valid}, 64'd1);
      check("R1 hit", {63'd0, out_hit}, {63'd0, VECS[i].e_hit});
      check("R3/R6-R10 fault", {62'd0, out_fault}, {62'd0, VECS[i].e_flt});
      check("R4/R5 addr", out_addr, VECS[i].e_addr);
      check("R11 accept", {63'd0, out_accept},
            {63'd0, VECS[i].e_hit && VECS[i].e_flt == 2'd0});
      if (VECS[i].e_hit)
        check("R5 src", {61'd0, out_src}, {61'd0, VECS[i].rm[2:0]});
    end

    // R2 idle beat: no valid next cycle
    @(negedge clk);
    check("R2 idle", {63'd0, out_valid}, 64'd0);

    // R1 wrong second opcode byte
    op_byte1 = 8'h1F;
    apply('{2'd3,1'b0,1'b1,1'b0,1'b0,3'd0,1'b0,8'hF0,64'h40,32'h0,1'b1,2'd0,64'h40});
    check("R1 bad byte hit", {63'd0, out_hit}, 64'd0);
    check("R1 bad byte accept", {63'd0, out_accept}, 64'd0);
    check("R1 bad byte addr", out_addr, 64'd0);
    op_byte1 = 8'h0F;

    // R2 back-to-back beats
    @(negedge clk);
    in_valid = 1'b1; cpu_mode = 2'd3; eff_addr = 64'h111; modrm = 8'hF1;
    @(negedge clk);
    check("R2 b2b first", out_addr, 64'h111);
    eff_addr = 64'h222; modrm = 8'hF2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 b2b second", out_addr, 64'h222);
    check("R5 b2b src", {61'd0, out_src}, 64'd2);
    @(negedge clk);
    check("R2 b2b end", {63'd0, out_valid}, 64'd0);

    // R12 reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset addr", out_addr, 64'd0);
    check("R12 reset valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule